// File: doc/BRIEF.md
# Chip-Select and Wait-State Generator

This block sits between a bus master and its external memories and peripherals. It watches a 24-bit address bus together with the memory-request and I/O-request strobes and drives one active-low select line for each configured channel. A channel set for memory space claims a range of 64 KB blocks, given as an inclusive lower and upper block number. A channel set for I/O space claims one 256-byte page of the I/O map.

Each channel also has a wait-state count from 0 to 7. When a bus access starts, the count of the winning channel is loaded once, and the ready line back to the master stays low for that many clock cycles. After that, an external active-low WAIT pin can hold ready low for as long as a slow device needs. Channel configuration comes in on static configuration ports, which a surrounding register block drives. When several channels claim the same address, the lowest-numbered one takes it.

Top module: `cs_wait_gen`

## Requirements
- R1: While rst_n is low, with no request strobe low, every cs_n bit is 1 and rdy is 1.
- R2: A channel i with cfg_en[i]=1 and cfg_io[i]=0 (0 selects memory space) matches in the same cycle when mreq_n=0, iorq_n=1, and addr[23:16] lies between cfg_lo[i*8+:8] and cfg_hi[i*8+:8], both bounds included.
- R3: A channel i with cfg_en[i]=1 and cfg_io[i]=1 (1 selects I/O space) matches in the same cycle when iorq_n=0, mreq_n=1 and addr[15:8] equals cfg_page[i*8+:8].
- R4: A channel with cfg_en[i]=0 never drives its cs_n bit low, whatever the address and strobes.
- R5: When several channels match, only the lowest-numbered matching channel drives its cs_n bit low. At most one cs_n bit is ever low.
- R6: When mreq_n and iorq_n are both 1, every cs_n bit is 1.
- R7: An access is active while (mreq_n=0 or iorq_n=0) and (rd_n=0 or wr_n=0). With wait_n=1, rdy is 0 for exactly W cycles from the first active cycle on, where W is cfg_wait[i*3+:3] of the winning channel, or 0 if no channel matches.
- R8: Once the W cycles have elapsed, rdy is 0 in every cycle of the access in which wait_n=0 and 1 in every cycle in which wait_n=1.
- R9: While no access is active, rdy is 1 whatever wait_n is.
- R10: The wait count is loaded once per access. After rdy has risen, a held access does not reload it. The access must go inactive for at least one cycle before a new count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 24 | Bus address |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wait_n | input | 1 | External wait request, active low |
| cfg_en | input | 4 | Per-channel enable |
| cfg_io | input | 4 | Per-channel space: 0 memory, 1 I/O |
| cfg_lo | input | 32 | Per-channel lower 64 KB block number, 8 bits each |
| cfg_hi | input | 32 | Per-channel upper 64 KB block number, 8 bits each |
| cfg_page | input | 32 | Per-channel I/O page, 8 bits each |
| cfg_wait | input | 12 | Per-channel wait states, 3 bits each |
| cs_n | output | 4 | Chip selects, active low |
| rdy | output | 1 | Ready to the bus master, active high |

## Verification
The selects are combinational, so a wrong bound comparison, a wrong space test or a broken priority shows on cs_n in the same cycle the address is driven. A sweep over every block number and every I/O page finds it at the first value where it matters. The only state is the wait counter and its phase flag. If either one is corrupted, the number of low rdy cycles in an access is wrong, or rdy falls again after it has risen, and this appears within eight cycles of the access starting.

// File: rtl/cswg_pkg.sv
package cswg_pkg;
   // Phase of the bus cycle as seen by the wait counter
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_BUSY = 1'b1
   } cyc_phase_e;

   // Address space selected by a channel's space bit
   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;
endpackage

// File: rtl/cswg_chan_dec.sv
module cswg_chan_dec #(
   parameter int TAG_W  = 8,
   parameter int PAGE_W = 8
) (
   input  logic              en,
   input  logic              space,
   input  logic              mem_act,
   input  logic              io_act,
   input  logic [TAG_W-1:0]  tag,
   input  logic [PAGE_W-1:0] page,
   input  logic [TAG_W-1:0]  lo,
   input  logic [TAG_W-1:0]  hi,
   input  logic [PAGE_W-1:0] sel_page,
   output logic              hit
);
   import cswg_pkg::*;

   logic mem_hit;
   logic io_hit;

   always_comb begin
      mem_hit = (space == SPACE_MEM) && mem_act && (tag >= lo) && (tag <= hi);
      io_hit  = (space == SPACE_IO) && io_act && (page == sel_page);
      hit     = en && (mem_hit || io_hit);
   end
endmodule

// File: rtl/cswg_prio.sv
module cswg_prio #(
   parameter int NUM_CS   = 4,
   parameter bit LOW_WINS = 1'b1
) (
   input  logic [NUM_CS-1:0] hit,
   output logic [NUM_CS-1:0] grant
);
   generate
      if (LOW_WINS) begin : g_low
         always_comb begin
            logic taken;
            taken = 1'b0;
            grant = '0;
            for (int i = 0; i < NUM_CS; i++) begin
               if (hit[i] && !taken) begin
                  grant[i] = 1'b1;
                  taken    = 1'b1;
               end
            end
         end
      end else begin : g_high
         always_comb begin
            logic taken;
            taken = 1'b0;
            grant = '0;
            for (int i = NUM_CS - 1; i >= 0; i--) begin
               if (hit[i] && !taken) begin
                  grant[i] = 1'b1;
                  taken    = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cswg_wait_ctr.sv
module cswg_wait_ctr #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access,
   input  logic [WAIT_W-1:0] load_val,
   input  logic              wait_n,
   output logic              rdy
);
   import cswg_pkg::*;

   cyc_phase_e        phase_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W-1:0] remain;
   logic              first;

   always_comb begin
      first  = access && (phase_q == PH_IDLE);
      remain = first ? load_val : cnt_q;
      rdy    = !access || ((remain == '0) && wait_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (!access) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= PH_BUSY;
         cnt_q   <= (remain != '0) ? remain - WAIT_W'(1) : '0;
      end
   end
endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen #(
   parameter int NUM_CS      = 4,
   parameter int ADDR_W      = 24,
   parameter int MEM_ALIGN_W = 16,
   parameter int IO_PAGE_LSB = 8,
   parameter int IO_PAGE_W   = 8,
   parameter int WAIT_W      = 3,
   parameter bit LOW_WINS    = 1'b1,
   localparam int TAG_W      = ADDR_W - MEM_ALIGN_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        mreq_n,
   input  logic                        iorq_n,
   input  logic                        rd_n,
   input  logic                        wr_n,
   input  logic                        wait_n,
   input  logic [NUM_CS-1:0]           cfg_en,
   input  logic [NUM_CS-1:0]           cfg_io,
   input  logic [NUM_CS*TAG_W-1:0]     cfg_lo,
   input  logic [NUM_CS*TAG_W-1:0]     cfg_hi,
   input  logic [NUM_CS*IO_PAGE_W-1:0] cfg_page,
   input  logic [NUM_CS*WAIT_W-1:0]    cfg_wait,
   output logic [NUM_CS-1:0]           cs_n,
   output logic                        rdy
);
   // Elaboration-time parameter checks
   generate
      if (NUM_CS < 1) begin : g_bad_count
         $error("cs_wait_gen: NUM_CS must be at least 1");
      end
      if (ADDR_W <= MEM_ALIGN_W) begin : g_bad_align
         $error("cs_wait_gen: MEM_ALIGN_W must be below ADDR_W");
      end
      if (IO_PAGE_LSB + IO_PAGE_W > ADDR_W) begin : g_bad_page
         $error("cs_wait_gen: I/O page field exceeds the address");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("cs_wait_gen: WAIT_W must be at least 1");
      end
   endgenerate

   logic                 mem_act;
   logic                 io_act;
   logic                 access;
   logic [TAG_W-1:0]     tag;
   logic [IO_PAGE_W-1:0] page;
   logic [NUM_CS-1:0]    hit;
   logic [NUM_CS-1:0]    grant;
   logic [WAIT_W-1:0]    sel_wait;
   logic                 unused_addr_par;

   always_comb begin
      mem_act = !mreq_n && iorq_n;
      io_act  = !iorq_n && mreq_n;
      access  = (!mreq_n || !iorq_n) && (!rd_n || !wr_n);
      tag     = addr[ADDR_W-1 -: TAG_W];
      page    = addr[IO_PAGE_LSB +: IO_PAGE_W];
   end

   assign unused_addr_par = ^addr;

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_chan
         cswg_chan_dec #(
            .TAG_W  (TAG_W),
            .PAGE_W (IO_PAGE_W)
         ) u_dec (
            .en       (cfg_en[i]),
            .space    (cfg_io[i]),
            .mem_act  (mem_act),
            .io_act   (io_act),
            .tag      (tag),
            .page     (page),
            .lo       (cfg_lo[i*TAG_W +: TAG_W]),
            .hi       (cfg_hi[i*TAG_W +: TAG_W]),
            .sel_page (cfg_page[i*IO_PAGE_W +: IO_PAGE_W]),
            .hit      (hit[i])
         );
      end
   endgenerate

   cswg_prio #(
      .NUM_CS   (NUM_CS),
      .LOW_WINS (LOW_WINS)
   ) u_prio (
      .hit   (hit),
      .grant (grant)
   );

   always_comb begin
      sel_wait = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         sel_wait = sel_wait | (cfg_wait[i*WAIT_W +: WAIT_W] & {WAIT_W{grant[i]}});
      end
      cs_n = ~grant;
   end

   cswg_wait_ctr #(
      .WAIT_W (WAIT_W)
   ) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .access   (access),
      .load_val (sel_wait),
      .wait_n   (wait_n),
      .rdy      (rdy)
   );
endmodule

// File: rtl/cswg_chk.sv
module cswg_chk #(
   parameter int NUM_CS = 4,
   parameter int WAIT_W = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     mreq_n,
   input logic                     iorq_n,
   input logic                     rd_n,
   input logic                     wr_n,
   input logic                     wait_n,
   input logic [NUM_CS-1:0]        cfg_en,
   input logic [NUM_CS*WAIT_W-1:0] cfg_wait,
   input logic [NUM_CS-1:0]        cs_n,
   input logic                     rdy
);
   logic              bus_on;
   logic [WAIT_W-1:0] won_wait;

   always_comb begin
      bus_on   = (!mreq_n || !iorq_n) && (!rd_n || !wr_n);
      won_wait = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (!cs_n[i]) won_wait = cfg_wait[i*WAIT_W +: WAIT_W];
      end
   end

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_dis
         // R4
         disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[i] |-> cs_n[i]);
      end
   endgenerate

   // R5
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R6
   no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_n && iorq_n) |-> (&cs_n));

   // R7
   first_cycle_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_on) |-> (rdy == ((won_wait == '0) && wait_n)));

   // R8
   wait_pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_on && $past(bus_on) && $past(rdy)) |-> (rdy == wait_n));

   // R9
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_on |-> rdy);
endmodule

bind cs_wait_gen cswg_chk #(
   .NUM_CS (NUM_CS),
   .WAIT_W (WAIT_W)
) u_cswg_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mreq_n   (mreq_n),
   .iorq_n   (iorq_n),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .wait_n   (wait_n),
   .cfg_en   (cfg_en),
   .cfg_wait (cfg_wait),
   .cs_n     (cs_n),
   .rdy      (rdy)
);

// File: tb/tb_cs_wait_gen.sv
`timescale 1ns/1ps
module tb_cs_wait_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] addr = '0;
   logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, wait_n = 1'b1;
   logic [3:0]  en, sp;
   logic [7:0]  lo [4];
   logic [7:0]  hi [4];
   logic [7:0]  pg [4];
   logic [2:0]  wt [4];
   logic [31:0] cfg_lo, cfg_hi, cfg_page;
   logic [11:0] cfg_wait;
   logic [3:0]  cs_n;
   logic        rdy;
   int          n_run = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 4; i++) begin
         cfg_lo[i*8 +: 8]   = lo[i];
         cfg_hi[i*8 +: 8]   = hi[i];
         cfg_page[i*8 +: 8] = pg[i];
         cfg_wait[i*3 +: 3] = wt[i];
      end
   end

   cs_wait_gen dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
      .rd_n(rd_n), .wr_n(wr_n), .wait_n(wait_n), .cfg_en(en), .cfg_io(sp),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_page(cfg_page), .cfg_wait(cfg_wait),
      .cs_n(cs_n), .rdy(rdy)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_cs(input logic [23:0] a, input logic m_n, input logic i_n);
      logic [3:0] r;
      r = 4'hF;
      for (int i = 0; i < 4; i++) begin
         if (r == 4'hF && en[i] &&
             ((!sp[i] && !m_n && i_n && a[23:16] >= lo[i] && a[23:16] <= hi[i]) ||
              (sp[i] && !i_n && m_n && a[15:8] == pg[i])))
            r[i] = 1'b0;
      end
      return r;
   endfunction

   task automatic go_idle();
      @(negedge clk);
      mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; wait_n = 1'b1;
   endtask

   // One access; counts rdy-low cycles, then checks rdy stays high (R10)
   task automatic run_access(input logic [23:0] a, input bit io_sp, input bit use_wr,
                             input int hold, output int lows);
      @(negedge clk);
      addr = a; mreq_n = io_sp; iorq_n = !io_sp; rd_n = use_wr; wr_n = !use_wr;
      lows = 0;
      for (int k = 0; k < 20; k++) begin
         if (k > 0) @(negedge clk);
         wait_n = (k < hold) ? 1'b0 : 1'b1;
         #1;
         if (rdy) break;
         lows++;
      end
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk("R10 no reload while held", rdy, 1);
      end
      go_idle();
   endtask

   task automatic sweep(input string tagm);
      for (int a = 0; a < 256; a++) begin
         for (int m = 0; m < 3; m++) begin
            @(negedge clk);
            mreq_n = (m != 0); iorq_n = (m != 1); rd_n = 1'b0;
            addr = (m == 1) ? {8'h77, a[7:0], 8'hC3} : {a[7:0], 16'h5A3C};
            #1;
            chk(m == 0 ? {tagm, " R2 R5 memory"} : (m == 1 ? {tagm, " R3 R5 io"} : {tagm, " R6 no strobe"}),
                cs_n, exp_cs(addr, mreq_n, iorq_n));
         end
      end
      go_idle();
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int lows;
      en = 4'hF; sp = 4'b1100;
      lo[0] = 8'h10; hi[0] = 8'h1F; pg[0] = 8'h00; wt[0] = 3'd1;
      lo[1] = 8'h18; hi[1] = 8'h40; pg[1] = 8'h00; wt[1] = 3'd3;
      lo[2] = 8'h00; hi[2] = 8'hFF; pg[2] = 8'h12; wt[2] = 3'd5;
      lo[3] = 8'h00; hi[3] = 8'hFF; pg[3] = 8'h12; wt[3] = 3'd7;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset cs", cs_n, 4'hF);
      chk("R1 reset rdy", rdy, 1);
      @(negedge clk); rst_n = 1'b1;

      // R9: idle with WAIT asserted
      @(negedge clk); wait_n = 1'b0; #1;
      chk("R9 idle rdy", rdy, 1);
      @(negedge clk); mreq_n = 1'b0; addr = 24'h120000; #1;
      chk("R9 strobe without rd/wr", rdy, 1);
      go_idle();

      sweep("full");
      // R5 explicit overlaps
      @(negedge clk); mreq_n = 1'b0; addr = 24'h1A0000; #1;
      chk("R5 overlap memory", cs_n, 4'b1110);
      @(negedge clk); mreq_n = 1'b1; iorq_n = 1'b0; addr = 24'h001200; #1;
      chk("R5 overlap io", cs_n, 4'b1011);
      @(negedge clk); mreq_n = 1'b0; iorq_n = 1'b0; #1;
      chk("R3 both strobes", cs_n, 4'hF);
      go_idle();

      // R4: disabled channels
      en = 4'b1110;
      sweep("ch0 off R4");
      @(negedge clk); mreq_n = 1'b0; addr = 24'h1A0000; #1;
      chk("R4 ch0 off", cs_n, 4'b1101);
      en = 4'b0000;
      @(negedge clk); mreq_n = 1'b1; iorq_n = 1'b0; addr = 24'h001200; #1;
      chk("R4 all off", cs_n, 4'hF);
      go_idle();
      en = 4'hF;

      // R7: wait counts per channel and value
      for (int w = 0; w < 8; w++) begin
         wt[0] = w[2:0];
         run_access(24'h100000, 1'b0, 1'b0, 0, lows); chk("R7 ch0 waits", lows, w);
         wt[1] = w[2:0];
         run_access(24'h300000, 1'b0, 1'b1, 0, lows); chk("R7 ch1 waits", lows, w);
         wt[2] = w[2:0]; wt[3] = 3'd7 - w[2:0];
         run_access(24'h001200, 1'b1, 1'b0, 0, lows); chk("R7 io priority waits", lows, w);
      end
      run_access(24'h800000, 1'b0, 1'b0, 0, lows); chk("R7 no match", lows, 0);

      // R8: external WAIT extension
      wt[1] = 3'd2;
      run_access(24'h300000, 1'b0, 1'b0, 5, lows); chk("R8 wait beyond count", lows, 5);
      run_access(24'h300000, 1'b0, 1'b1, 2, lows); chk("R8 wait equals count", lows, 2);
      wt[1] = 3'd3;
      run_access(24'h300000, 1'b0, 1'b0, 1, lows); chk("R8 wait inside count", lows, 3);
      wt[1] = 3'd0;
      run_access(24'h300000, 1'b0, 1'b0, 4, lows); chk("R8 zero count", lows, 4);

      // R8: WAIT reasserted after rdy rose
      wt[1] = 3'd1;
      @(negedge clk); addr = 24'h300000; mreq_n = 1'b0; rd_n = 1'b0; #1;
      chk("R7 first cycle", rdy, 0);
      @(negedge clk); #1; chk("R7 count done", rdy, 1);
      @(negedge clk); wait_n = 1'b0; #1; chk("R8 late wait", rdy, 0);
      @(negedge clk); wait_n = 1'b1; #1; chk("R8 late release", rdy, 1);
      go_idle();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule